// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 32-bit virtual address onto a 30-bit physical address. It keeps a small table of relocation entries, one per segment. The two most significant address bits pick the entry, and the remaining 30 bits act as the offset inside that segment. Each entry records where its segment starts in physical memory and how many bytes it spans. The block adds the offset to the start and, in parallel, compares the offset with the span.

Software loads the table through a one-cycle write port that carries an entry index, a start address, a size and a write strobe. Each lookup request produces a registered response one cycle later. The response carries either the physical address or a fault flag. A fault is raised when the offset falls outside the segment, or when the segment was never loaded since reset.

Top module: `segxlat_top`

## Requirements
- R1: The segment index is virtual address bits [31:30] and the offset is bits [29:0].
- R2: For an in-range lookup the physical address is (segment start + offset) modulo 2^30.
- R3: A lookup faults when offset >= segment size; offset = size-1 is in range.
- R4: Reset marks every entry as unloaded, and a lookup into an unloaded entry faults.
- R5: When the fault flag is 1, the physical address output is 0.
- R6: rspValid is 1 in exactly the cycle after a cycle with reqValid = 1. While rspValid is 0, rspPaddr and rspFault are 0.
- R7: A table write and a lookup of the same entry in one cycle: the lookup uses the entry's previous contents.
- R8: A write replaces both the start and the size of the addressed entry and marks that entry as loaded.
- R9: With entries 0 = (0x4000, 0x700), 1 = (0x0, 0x500) and 2 = (0x2000, 0x1000), the results are as follows. Virtual offset 0x200 in segment 2 gives 0x2200. Offset 0x6ff in segment 0 gives 0x46ff. Offset 0x4ff in segment 1 gives 0x4ff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgIdx | input | 2 | Entry index to write |
| cfgBase | input | 30 | Physical start address for the entry |
| cfgSize | input | 30 | Segment size in bytes |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspPaddr | output | 30 | Translated physical address (0 on fault) |
| rspFault | output | 1 | Out-of-range or unloaded segment |

## Verification
A table write and a lookup can land in the same cycle, and they can address the same entry. The bench creates this case on purpose: it rewrites segment 2 with a much smaller size in the same cycle that it looks up an offset the old size allowed. The response must still show the old translation. The next lookup of that offset must then fault under the new size. During the random phase, writes and lookups overlap freely. A cycle-level model checks every response against the table as it stood before that cycle's write.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic tableWr;   // commit a table entry this cycle
    logic lookup;    // capture a translation result this cycle
  } xlatStrobeT;
endpackage

// File: rtl/segxlat_ctrl.sv
module segxlat_ctrl
  import segxlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       reqValid,
  output xlatStrobeT strobes,
  output logic       rspValid
);
  always_comb begin
    strobes.tableWr = cfgWrEn;
    strobes.lookup  = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R6
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R6
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/segxlat_dp.sv
module segxlat_dp
  import segxlat_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int SEG_BITS = 2,
  parameter int PA_W     = 30
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlatStrobeT          strobes,
  input  logic [SEG_BITS-1:0] cfgIdx,
  input  logic [PA_W-1:0]     cfgBase,
  input  logic [VA_W-SEG_BITS-1:0] cfgSize,
  input  logic [VA_W-1:0]     reqVaddr,
  output logic [PA_W-1:0]     rspPaddr,
  output logic                rspFault
);
  localparam int OFF_W   = VA_W - SEG_BITS;
  localparam int NUM_SEG = 1 << SEG_BITS;

  logic [PA_W-1:0]  baseQ [NUM_SEG];
  logic [OFF_W-1:0] sizeQ [NUM_SEG];
  logic [NUM_SEG-1:0] loadedQ;

  // One register set per entry.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g]   <= '0;
        sizeQ[g]   <= '0;
        loadedQ[g] <= 1'b0;
      end else if (strobes.tableWr && cfgIdx == SEG_BITS'(g)) begin
        baseQ[g]   <= cfgBase;
        sizeQ[g]   <= cfgSize;
        loadedQ[g] <= 1'b1;
      end
    end
  end

  logic [SEG_BITS-1:0] segSel;
  logic [OFF_W-1:0]    offset;
  logic [PA_W-1:0]     selBase;
  logic [OFF_W-1:0]    selSize;
  logic                selLoaded;
  logic [PA_W-1:0]     sumC;
  logic                pastLimit;
  logic                faultC;

  always_comb begin
    segSel    = reqVaddr[VA_W-1 -: SEG_BITS];
    offset    = reqVaddr[OFF_W-1:0];
    selBase   = baseQ[segSel];
    selSize   = sizeQ[segSel];
    selLoaded = loadedQ[segSel];
    // Adder and limit compare both work on the raw offset, side by side.
    sumC      = selBase + PA_W'(offset);
    pastLimit = (offset >= selSize);
    faultC    = !selLoaded || pastLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspFault <= 1'b0;
    end else if (strobes.lookup) begin
      rspFault <= faultC;
      rspPaddr <= faultC ? '0 : sumC;
    end else begin
      rspPaddr <= '0;
      rspFault <= 1'b0;
    end
  end

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspPaddr == '0);
  // R4
  unloaded_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookup && !selLoaded) |=> rspFault);
  // R3
  bound_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookup && offset >= selSize) |=> rspFault);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lookup |=> (rspPaddr == '0 && !rspFault));
endmodule

// File: rtl/segxlat_top.sv
module segxlat_top
  import segxlat_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int SEG_BITS = 2,
  parameter int PA_W     = 30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [SEG_BITS-1:0]      cfgIdx,
  input  logic [PA_W-1:0]          cfgBase,
  input  logic [VA_W-SEG_BITS-1:0] cfgSize,
  input  logic                     reqValid,
  input  logic [VA_W-1:0]          reqVaddr,
  output logic                     rspValid,
  output logic [PA_W-1:0]          rspPaddr,
  output logic                     rspFault
);
  xlatStrobeT strobes;

  segxlat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  segxlat_dp #(.VA_W(VA_W), .SEG_BITS(SEG_BITS), .PA_W(PA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgIdx   (cfgIdx),
    .cfgBase  (cfgBase),
    .cfgSize  (cfgSize),
    .reqVaddr (reqVaddr),
    .rspPaddr (rspPaddr),
    .rspFault (rspFault)
  );
endmodule

// File: tb/segxlat_top_test.sv
module segxlat_top_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgIdx;
  logic [29:0] cfgBase;
  logic [29:0] cfgSize;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic        rspValid;
  logic [29:0] rspPaddr;
  logic        rspFault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference table kept in the bench.
  logic [29:0] mBase [4];
  logic [29:0] mSize [4];
  bit          mLoad [4];

  always #4 clk = ~clk;  // 125 MHz

  segxlat_top uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgBase(cfgBase), .cfgSize(cfgSize), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWrEn = 1'b0; reqValid = 1'b0;
    cfgIdx = '0; cfgBase = '0; cfgSize = '0; reqVaddr = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      mBase[i] = '0; mSize[i] = '0; mLoad[i] = 0;
    end
    rstN = 1'b1;
    #2;
    // R6: quiet outputs out of reset
    chk(rspValid == 1'b0, "R6", "reset rspValid", 32'(rspValid), 32'd0);
    chk(rspPaddr == '0 && !rspFault, "R6", "reset data",
        32'(rspPaddr), 32'd0);
  endtask

  // One cycle: drive at negedge, update model at posedge, compare after it.
  task automatic step(input bit wr, input logic [1:0] idx,
                      input logic [29:0] b, input logic [29:0] s,
                      input bit rq, input logic [31:0] va, input string tag);
    logic [1:0]  seg;
    logic [29:0] off;
    logic [29:0] expPa;
    bit          expFault;
    @(negedge clk);
    cfgWrEn = wr; cfgIdx = idx; cfgBase = b; cfgSize = s;
    reqValid = rq; reqVaddr = va;
    @(posedge clk);
    seg = va[31:30];
    off = va[29:0];
    expFault = rq && (!mLoad[seg] || off >= mSize[seg]);
    expPa    = (rq && !expFault) ? (mBase[seg] + off) : 30'd0;
    if (wr) begin
      mBase[idx] = b; mSize[idx] = s; mLoad[idx] = 1;
    end
    #2;
    chk(rspValid == rq, "R6", "rspValid", 32'(rspValid), 32'(rq));
    chk(rspFault == expFault, tag, "rspFault", 32'(rspFault), 32'(expFault));
    chk(rspPaddr == expPa, tag, "rspPaddr", 32'(rspPaddr), 32'(expPa));
  endtask

  task automatic wrOnly(input logic [1:0] idx, input logic [29:0] b,
                        input logic [29:0] s);
    step(1, idx, b, s, 0, 32'h0, "R8");
  endtask

  task automatic look(input logic [1:0] seg, input logic [29:0] off,
                      input string tag);
    step(0, 2'd0, 30'd0, 30'd0, 1, {seg, off}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    doReset();
    // R4: all entries unloaded after reset
    look(2'd2, 30'h200, "R4");
    look(2'd0, 30'h0, "R4");
    // R9 layout
    wrOnly(2'd0, 30'h4000, 30'h700);
    wrOnly(2'd1, 30'h0, 30'h500);
    wrOnly(2'd2, 30'h2000, 30'h1000);
    look(2'd2, 30'h200, "R9");
    look(2'd0, 30'h6ff, "R9");
    look(2'd1, 30'h4ff, "R9");
    // R1: segment taken from top bits only
    look(2'd1, 30'h123, "R1");
    look(2'd3, 30'h0, "R4");
    // R3: boundary
    look(2'd0, 30'h700, "R3");
    look(2'd2, 30'hfff, "R3");
    look(2'd2, 30'h1000, "R3");
    look(2'd1, 30'h3fffffff, "R3");
    // R7: same-cycle write and lookup of entry 2 sees old contents
    step(1, 2'd2, 30'h8000, 30'h100, 1, {2'd2, 30'h200}, "R7");
    // R8: new contents in force afterwards
    look(2'd2, 30'h200, "R8");
    look(2'd2, 30'h50, "R8");
    // R7: first write to unloaded entry 3 with a lookup in the same cycle
    step(1, 2'd3, 30'h3fffff00, 30'h3fffffff, 1, {2'd3, 30'h10}, "R7");
    // R2: wrap modulo 2^30
    look(2'd3, 30'h200, "R2");
    // back-to-back lookups and idle gaps
    look(2'd0, 30'h10, "R2");
    step(0, 2'd0, 30'd0, 30'd0, 0, 32'h0, "R6");
    look(2'd1, 30'h0, "R2");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2, r3;
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      step(r1[0] & r1[1], r1[3:2], r2[29:0], {14'd0, r3[15:0]},
           r1[4] | r1[5], {r1[7:6], 14'd0, r3[31:16] ^ r2[15:0]}, "R2");
    end
    // R4: a second reset clears the table again
    doReset();
    look(2'd0, 30'h10, "R4");
    look(2'd2, 30'h200, "R4");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule